// File: doc/BRIEF.md
# Packed Integer Lane Width Converter

This block converts a word of packed integer elements from one element width to another. Narrowing turns each wide source element into a narrower destination element. Depending on a persistent mode setting, the element is either cut down to its low bits or clamped into the destination's signed or unsigned range. Widening extends each narrow element with copies of its sign bit or with zeros, as the caller selects. Narrowed results are packed contiguously from bit 0 of the output word, and any output bits above them are zero.

Whether narrowing wraps or clamps is not chosen per operation. A one-bit mode register holds it. Software writes the register once, and the setting applies to every following operation until the next write, in the same way a rounding mode is held. A sticky flag records that some element was clamped. It stays set until it is explicitly cleared, so a long run of conversions can be checked once at the end. Each operation is presented for one cycle, and the result is registered.

Top module: `lnc_lane_conv`

## Requirements
- R1: A 2-bit width code c selects an element width of 8<<c bits (0=8, 1=16, 2=32, 3=64). A destination code below the source code narrows and a destination code above it widens. Equal codes copy the word unchanged and never raise the flag.
- R2: When narrowing from N to M bits, source element i (bits i*N upward) lands at bits i*M upward. All result bits from (64/N)*M upward are zero.
- R3: In wrap mode (mode value 0), each narrowed element is the low M bits of its source element, and no saturation is flagged.
- R4: In clamp mode (mode value 1) with dst_signed=1, each element is limited to the range -2^(M-1) to 2^(M-1)-1. The source element is read as signed when src_signed=1 and as unsigned when src_signed=0.
- R5: In clamp mode with dst_signed=0, each element is limited to the range 0 to 2^M-1. A negative element from a signed source gives 0.
- R6: When widening from N to M bits, source element i at bits i*N becomes result element i at bits i*M. It is sign-extended when src_signed=1 and zero-extended otherwise. Only the low 64/M source elements are used and the rest of the source is ignored. Widening is unaffected by the mode and never raises the flag.
- R7: mode_in is loaded into the mode register on a cycle with mode_wr=1, and the mode persists until the next write. An operation issued in the same cycle as a write still uses the previous mode.
- R8: res_word and res_valid=1 appear one cycle after op_valid. While op_valid is low, res_word holds and res_valid is 0.
- R9: sat_flag is set one cycle after an operation in which any element had to be clamped. An element that already equals a bound is not counted. The flag stays set until sat_clr. When a clear and a new clamp fall in the same cycle, the flag ends up set.
- R10: After reset, res_word is 0, res_valid is 0, sat_flag is 0 and the mode is wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load mode_in into the mode register |
| mode_in | input | 1 | New mode: 0 wrap, 1 clamp |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| op_valid | input | 1 | Perform a conversion this cycle |
| src_word | input | 64 | Packed source elements |
| src_wcode | input | 2 | Source element width code |
| dst_wcode | input | 2 | Destination element width code |
| src_signed | input | 1 | Source elements are signed (also selects sign extension) |
| dst_signed | input | 1 | Clamp to the signed destination range |
| res_word | output | 64 | Packed converted elements |
| res_valid | output | 1 | res_word was updated in the previous cycle |
| sat_flag | output | 1 | Sticky: some element was clamped |

## Verification
The sweep covers every pair of width codes, both signedness inputs and both modes. Lane values are chosen from the points where clamping changes: each bound, one past it, and the extremes of the source range. A design whose comparison is off by one at a bound would clamp a value that is already legal and raise the flag for it. A design that treats an unsigned 64-bit source as signed would pass its top-half values through as negatives instead of clamping them to the maximum. Directed cases cover an operation issued in the same cycle as a mode write, which must use the old mode, and a clear that meets a fresh clamp, which must leave the flag set. They also confirm that a narrowed word has zero upper bits, which catches stale or unmasked lanes.

// File: rtl/lnc_pkg.sv
package lnc_pkg;

    localparam int ELEM_W  = 64;            // widest element handled
    localparam int EXT_W   = ELEM_W + 2;    // sign plus guard for range compares
    localparam int WCODE_W = 2;

    typedef logic [WCODE_W-1:0]      wcode_t;
    typedef logic signed [EXT_W-1:0] wide_t;

    typedef enum logic {
        MODE_WRAP  = 1'b0,
        MODE_CLAMP = 1'b1
    } sat_mode_e;

    typedef enum logic [1:0] {
        DIR_COPY   = 2'd0,
        DIR_NARROW = 2'd1,
        DIR_WIDEN  = 2'd2
    } conv_dir_e;

    typedef struct packed {
        logic [ELEM_W-1:0] bits;
        logic              sat;
    } lane_res_t;

    function automatic int unsigned code_bits(wcode_t c);
        return 32'd8 << c;
    endfunction

    function automatic logic [ELEM_W-1:0] low_mask(int unsigned n);
        if (n >= ELEM_W) return '1;
        return (ELEM_W'(1) << n) - ELEM_W'(1);
    endfunction

    function automatic conv_dir_e pick_dir(wcode_t s, wcode_t d);
        if (d < s) return DIR_NARROW;
        if (d > s) return DIR_WIDEN;
        return DIR_COPY;
    endfunction

    // Read the low element of raw as a number of the given width.
    function automatic wide_t extend_elem(logic [ELEM_W-1:0] raw, wcode_t c, logic sgn);
        wide_t       v;
        int unsigned n;
        logic        top;
        n   = code_bits(c);
        top = sgn & raw[n-1];
        for (int b = 0; b < EXT_W; b++) begin
            if (b < int'(n)) v[b] = raw[b];
            else             v[b] = top;
        end
        return v;
    endfunction

    // Fit a value into the destination width, clamping when the mode asks.
    function automatic lane_res_t fit_elem(wide_t v, wcode_t dc, logic dsgn, sat_mode_e m);
        lane_res_t   r;
        wide_t       hi;
        wide_t       lo;
        wide_t       pick;
        int unsigned mb;
        mb = code_bits(dc);
        if (dsgn) begin
            hi = (wide_t'(1) <<< (mb - 1)) - wide_t'(1);
            lo = -(wide_t'(1) <<< (mb - 1));
        end else begin
            hi = (wide_t'(1) <<< mb) - wide_t'(1);
            lo = '0;
        end
        pick  = v;
        r.sat = 1'b0;
        if (m == MODE_CLAMP) begin
            if (v > hi) begin
                pick  = hi;
                r.sat = 1'b1;
            end else if (v < lo) begin
                pick  = lo;
                r.sat = 1'b1;
            end
        end
        r.bits = pick[ELEM_W-1:0] & low_mask(mb);
        return r;
    endfunction

endpackage

// File: rtl/lnc_ctrl.sv
module lnc_ctrl
    import lnc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_wr,
    input  logic      mode_in,
    input  logic      sat_clr,
    input  logic      sat_evt,
    output sat_mode_e mode_q,
    output logic      sat_flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_WRAP;
            sat_flag <= 1'b0;
        end else begin
            if (mode_wr) mode_q <= sat_mode_e'(mode_in);
            sat_flag <= (sat_flag & ~sat_clr) | sat_evt;
        end
    end

    AST_MODE_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        !mode_wr |=> $stable(mode_q)); // R7
    AST_MODE_LOADS: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q == sat_mode_e'($past(mode_in)))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !sat_clr) |=> sat_flag); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !sat_evt) |=> !sat_flag); // R9

endmodule

// File: rtl/lnc_narrow_lane.sv
module lnc_narrow_lane
    import lnc_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX    = 0
) (
    input  logic [DATA_W-1:0] src_word,
    input  wcode_t            src_wcode,
    input  wcode_t            dst_wcode,
    input  logic              src_signed,
    input  logic              dst_signed,
    input  sat_mode_e         mode,
    output logic [ELEM_W-1:0] lane_bits,
    output logic              lane_sat,
    output logic              lane_active
);

    int unsigned       nb;
    logic [DATA_W-1:0] shifted;
    lane_res_t         fit;

    always_comb begin
        nb          = code_bits(src_wcode);
        shifted     = src_word >> (IDX * nb);
        lane_active = ((IDX + 1) * nb) <= DATA_W;
        fit         = fit_elem(extend_elem(ELEM_W'(shifted), src_wcode, src_signed),
                               dst_wcode, dst_signed, mode);
        lane_bits   = fit.bits;
        lane_sat    = fit.sat & lane_active;
    end

endmodule

// File: rtl/lnc_widen.sv
module lnc_widen
    import lnc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] src_word,
    input  wcode_t            src_wcode,
    input  wcode_t            dst_wcode,
    input  logic              src_signed,
    output logic [DATA_W-1:0] wide_word
);

    localparam int MAX_LANES = DATA_W / 16;

    int unsigned       nb;
    int unsigned       mb;
    wide_t             ext;
    logic [ELEM_W-1:0] placed;

    always_comb begin
        nb        = code_bits(src_wcode);
        mb        = code_bits(dst_wcode);
        wide_word = '0;
        ext       = '0;
        placed    = '0;
        for (int i = 0; i < MAX_LANES; i++) begin
            if ((i + 1) * mb <= DATA_W) begin
                ext       = extend_elem(ELEM_W'(src_word >> (i * nb)), src_wcode, src_signed);
                placed    = (ext[ELEM_W-1:0] & low_mask(mb)) << (i * mb);
                wide_word = wide_word | DATA_W'(placed);
            end
        end
    end

endmodule

// File: rtl/lnc_lane_conv.sv
module lnc_lane_conv
    import lnc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic              mode_in,
    input  logic              sat_clr,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] src_word,
    input  logic [1:0]        src_wcode,
    input  logic [1:0]        dst_wcode,
    input  logic              src_signed,
    input  logic              dst_signed,
    output logic [DATA_W-1:0] res_word,
    output logic              res_valid,
    output logic              sat_flag
);

    localparam int MAX_LANES = DATA_W / 16;   // narrowing sources are at least 16 bits

    sat_mode_e         mode_q;
    conv_dir_e         dir;
    logic [ELEM_W-1:0] lane_bits [MAX_LANES];
    logic [MAX_LANES-1:0] lane_sat;
    logic [MAX_LANES-1:0] lane_active;
    logic [DATA_W-1:0] narrow_word;
    logic [DATA_W-1:0] wide_word;
    logic [DATA_W-1:0] next_word;
    logic              any_sat;
    logic              sat_evt;
    int unsigned       mb;
    int unsigned       used_bits;

    lnc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_wr  (mode_wr),
        .mode_in  (mode_in),
        .sat_clr  (sat_clr),
        .sat_evt  (sat_evt),
        .mode_q   (mode_q),
        .sat_flag (sat_flag)
    );

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        lnc_narrow_lane #(.DATA_W(DATA_W), .IDX(g)) u_lane (
            .src_word    (src_word),
            .src_wcode   (src_wcode),
            .dst_wcode   (dst_wcode),
            .src_signed  (src_signed),
            .dst_signed  (dst_signed),
            .mode        (mode_q),
            .lane_bits   (lane_bits[g]),
            .lane_sat    (lane_sat[g]),
            .lane_active (lane_active[g])
        );
    end

    lnc_widen #(.DATA_W(DATA_W)) u_widen (
        .src_word   (src_word),
        .src_wcode  (src_wcode),
        .dst_wcode  (dst_wcode),
        .src_signed (src_signed),
        .wide_word  (wide_word)
    );

    always_comb begin
        dir         = pick_dir(src_wcode, dst_wcode);
        mb          = code_bits(dst_wcode);
        used_bits   = (DATA_W / code_bits(src_wcode)) * mb;
        narrow_word = '0;
        any_sat     = 1'b0;
        for (int i = 0; i < MAX_LANES; i++) begin
            if (lane_active[i]) begin
                narrow_word = narrow_word | DATA_W'(lane_bits[i] << (i * mb));
                any_sat     = any_sat | lane_sat[i];
            end
        end
        unique case (dir)
            DIR_NARROW: next_word = narrow_word;
            DIR_WIDEN:  next_word = wide_word;
            default:    next_word = src_word;
        endcase
        sat_evt = op_valid && (dir == DIR_NARROW) && any_sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_word  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) res_word <= next_word;
        end
    end

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dir == DIR_NARROW) |=> ((res_word >> $past(used_bits)) == '0)); // R2
    AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode_q == MODE_WRAP && !sat_clr) |=> (sat_flag == $past(sat_flag))); // R3
    AST_WIDEN_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dir != DIR_NARROW && !sat_clr) |=> (sat_flag == $past(sat_flag))); // R6
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(res_word) && !res_valid)); // R8
    AST_RESULT_VALID: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid); // R8

endmodule

// File: tb/lnc_lane_conv_bench.sv
module lnc_lane_conv_bench;

    typedef logic signed [67:0] big_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic        mode_in = 1'b0;
    logic        sat_clr = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] src_word = '0;
    logic [1:0]  src_wcode = '0;
    logic [1:0]  dst_wcode = '0;
    logic        src_signed = 1'b0;
    logic        dst_signed = 1'b0;
    logic [63:0] res_word;
    logic        res_valid;
    logic        sat_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lnc_lane_conv u_lnc_lane_conv (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(mode_in), .sat_clr(sat_clr),
        .op_valid(op_valid), .src_word(src_word), .src_wcode(src_wcode), .dst_wcode(dst_wcode),
        .src_signed(src_signed), .dst_signed(dst_signed),
        .res_word(res_word), .res_valid(res_valid), .sat_flag(sat_flag)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] msk(int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic big_t as_val(logic [63:0] raw, int n, logic sgn);
        big_t v;
        v = $signed({4'b0, raw & msk(n)});
        if (sgn && raw[n-1]) v = v - (big_t'(1) <<< n);
        return v;
    endfunction

    // Reference conversion written from the requirements.
    task automatic model(input logic [63:0] w, input int sc, input int dc, input logic ss,
                         input logic ds, input logic md,
                         output logic [63:0] res, output logic sat);
        int n, m;
        big_t v, hi, lo;
        n = 8 << sc;
        m = 8 << dc;
        res = '0;
        sat = 1'b0;
        if (dc == sc) begin
            res = w;
        end else if (dc < sc) begin
            hi = ds ? (big_t'(1) <<< (m - 1)) - 1 : (big_t'(1) <<< m) - 1;
            lo = ds ? -(big_t'(1) <<< (m - 1)) : big_t'(0);
            for (int i = 0; i < 64 / n; i++) begin
                v = as_val(w >> (i * n), n, ss);
                if (md) begin
                    if (v > hi) begin v = hi; sat = 1'b1; end
                    else if (v < lo) begin v = lo; sat = 1'b1; end
                end
                res = res | ((v[63:0] & msk(m)) << (i * m));
            end
        end else begin
            for (int i = 0; i < 64 / m; i++) begin
                v = as_val(w >> (i * n), n, ss);
                res = res | ((v[63:0] & msk(m)) << (i * m));
            end
        end
    endtask

    task automatic run_op(input logic [63:0] w, input int sc, input int dc, input logic ss,
                          input logic ds, input logic clr, input logic mw, input logic mi);
        @(negedge clk);
        src_word   = w;
        src_wcode  = 2'(sc);
        dst_wcode  = 2'(dc);
        src_signed = ss;
        dst_signed = ds;
        sat_clr    = clr;
        mode_wr    = mw;
        mode_in    = mi;
        op_valid   = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        sat_clr  = 1'b0;
        mode_wr  = 1'b0;
    endtask

    task automatic set_mode(input logic mi);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_in = mi;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] exp_w, held;
        logic        exp_s;
        big_t        cand [11];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset res_word", res_word, 64'd0);
        chk("R10 reset res_valid", 64'(res_valid), 64'd0);
        chk("R10 reset sat_flag", 64'(sat_flag), 64'd0);

        // Reset mode is wrap: 16->8 signed keeps low byte, no flag.
        run_op(64'h0123, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 mode wraps after reset", res_word, 64'h23);
        chk("R3 wrap raises no flag", 64'(sat_flag), 64'd0);
        chk("R8 res_valid after op", 64'(res_valid), 64'd1);
        held = res_word;
        @(negedge clk);
        chk("R8 res_valid drops when idle", 64'(res_valid), 64'd0);
        chk("R8 res_word holds when idle", res_word, held);

        // Same-cycle mode write: this op still wraps, the next one clamps.
        run_op(64'h0123, 1, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R7 op with mode write uses old mode", res_word, 64'h23);
        chk("R7 no flag under old mode", 64'(sat_flag), 64'd0);
        run_op(64'h0123, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 new mode persists and clamps", res_word, 64'h7f);
        chk("R9 flag set by clamp", 64'(sat_flag), 64'd1);
        run_op(64'h0005, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 flag sticky over clean op", 64'(sat_flag), 64'd1);
        @(negedge clk); sat_clr = 1'b1;
        @(negedge clk); sat_clr = 1'b0;
        chk("R9 flag cleared", 64'(sat_flag), 64'd0);
        // Exact bound is not a clamp.
        run_op(64'h007f, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 bound value not flagged", 64'(sat_flag), 64'd0);
        chk("R4 bound value passes", res_word, 64'h7f);
        // Unsigned 64-bit top half clamps to max of 32 unsigned.
        run_op(64'h8000_0000_0000_0000, 3, 2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R5 large unsigned source clamps", res_word, 64'hffff_ffff);
        chk("R9 clear and clamp same cycle leaves set", 64'(sat_flag), 64'd1);

        // Sweep every width pair, signedness and mode over boundary lane values.
        for (int md = 0; md < 2; md++) begin
            set_mode(1'(md));
            for (int sc = 0; sc < 4; sc++) begin
                for (int dc = 0; dc < 4; dc++) begin
                    int n, m, k;
                    n = 8 << sc;
                    m = 8 << dc;
                    k = (m < n) ? m : n;
                    cand[0]  = 0;
                    cand[1]  = 1;
                    cand[2]  = (big_t'(1) <<< (k - 1)) - 1;
                    cand[3]  = big_t'(1) <<< (k - 1);
                    cand[4]  = (big_t'(1) <<< k) - 1;
                    cand[5]  = big_t'(1) <<< k;
                    cand[6]  = (big_t'(1) <<< (n - 1)) - 1;
                    cand[7]  = big_t'(1) <<< (n - 1);
                    cand[8]  = (big_t'(1) <<< n) - 1;
                    cand[9]  = (big_t'(1) <<< n) - (big_t'(1) <<< (k - 1));
                    cand[10] = (big_t'(1) <<< n) - (big_t'(1) <<< (k - 1)) - 1;
                    for (int sg = 0; sg < 4; sg++) begin
                        for (int p = 0; p < 11; p++) begin
                            logic [63:0] w;
                            logic ss, ds;
                            string tag;
                            ss = sg[0];
                            ds = sg[1];
                            w = '0;
                            for (int i = 0; i < 64 / n; i++)
                                w = w | ((cand[(p + 3 * i) % 11][63:0] & msk(n)) << (i * n));
                            model(w, sc, dc, ss, ds, 1'(md), exp_w, exp_s);
                            run_op(w, sc, dc, ss, ds, 1'b1, 1'b0, 1'b0);
                            if (dc == sc)      tag = "R1 copy";
                            else if (dc > sc)  tag = "R6 widen";
                            else if (md == 0)  tag = "R3 narrow wrap";
                            else if (ds)       tag = "R4 signed clamp";
                            else               tag = "R5 unsigned clamp";
                            chk($sformatf("%s sc=%0d dc=%0d ss=%0d ds=%0d p=%0d", tag, sc, dc, ss, ds, p),
                                res_word, exp_w);
                            chk($sformatf("R9 flag sc=%0d dc=%0d md=%0d p=%0d", sc, dc, md, p),
                                64'(sat_flag), 64'(exp_s));
                            if (dc < sc)
                                chk("R2 upper bits zero", res_word >> ((64 / n) * m), 64'd0);
                        end
                    end
                end
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule